// File: doc/BRIEF.md
# Next-PC Sequencer for Branches and Jumps

This block works out where a 32-bit RISC-V-style core fetches next. It holds the program counter in a register. Each cycle it looks at the decoded control class of the current instruction, the two register operands and a sign-extended immediate, and then chooses between the sequential address and a redirect target. It also reports whether control flow was redirected. For jumps it produces the return address that goes back to the destination register.

A conditional branch compares the two operands under one of six conditions: equality, inequality, and signed and unsigned ordering. Branch and direct-jump offsets arrive in half-word units, so the target is the PC plus twice the immediate. The register-indirect jump adds a byte offset to the first operand and clears bit 0 of the sum. The PC register loads a parameterised reset vector under reset and advances only when the step enable is high.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` is loaded with the parameter `RESET_VEC` (default 32'h0000_1000).
- R2: With `ctl_class` = 2'd0 (sequential), `next_pc` equals `pc_q + 4` and `taken` is 0.
- R3: With `ctl_class` = 2'd1 (branch), a `cond` of 3'b000 is taken when `rs1_val == rs2_val`, and 3'b001 is taken when they differ.
- R4: A branch `cond` of 3'b100 is taken when `rs1_val < rs2_val` as two's-complement numbers, and 3'b101 is taken when `rs1_val >= rs2_val` as two's-complement numbers.
- R5: A branch `cond` of 3'b110 is taken when `rs1_val < rs2_val` as unsigned numbers, and 3'b111 is taken when `rs1_val >= rs2_val` as unsigned numbers.
- R6: A taken branch gives `next_pc = pc_q + 2*imm`. A branch that is not taken gives `pc_q + 4`.
- R7: With `ctl_class` = 2'd2 (direct jump), `taken` is 1 and `next_pc = pc_q + 2*imm`.
- R8: With `ctl_class` = 2'd3 (register jump), `taken` is 1 and `next_pc = (rs1_val + imm)` with bit 0 cleared.
- R9: For classes 2'd2 and 2'd3, `link_val = pc_q + 4`, and `link_we` is 1 unless `dest_idx` is 0. For classes 2'd0 and 2'd1, `link_we` and `link_val` are 0.
- R10: At a clock edge without reset, `pc_q` takes `next_pc` if `step_en` is 1 and otherwise keeps its value.
- R11: Branch `cond` values 3'b010 and 3'b011 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the PC register this edge |
| ctl_class | input | 2 | 0 sequential, 1 branch, 2 direct jump, 3 register jump |
| cond | input | 3 | Branch condition code |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm | input | 32 | Sign-extended immediate (half-word units for branch and direct jump) |
| dest_idx | input | 5 | Destination register index |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Control flow redirected |
| link_val | output | 32 | Return address for jumps |
| link_we | output | 1 | Write the return address |

## Verification
A wrong PC value does not stay hidden. It appears on `pc_q` in the cycle after the faulty edge, and it propagates into `next_pc` and `link_val` in that same cycle. The bench therefore compares every output against its own model on every step. A comparator error shows up only on the cycle that uses the bad condition, so each of the six conditions, and the two reserved codes, gets operands that fall just either side of its boundary. Those operands include mixed-sign pairs where the signed and unsigned orderings disagree.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN_DEF   = 32;
    localparam int REG_IDX_W  = 5;
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        CLS_SEQ    = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_JAL    = 2'd2,
        CLS_JALR   = 2'd3
    } ctl_class_e;

    typedef enum logic [2:0] {
        CND_EQ   = 3'b000,
        CND_NE   = 3'b001,
        CND_RSV2 = 3'b010,
        CND_RSV3 = 3'b011,
        CND_LT   = 3'b100,
        CND_GE   = 3'b101,
        CND_LTU  = 3'b110,
        CND_GEU  = 3'b111
    } cond_e;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

    function automatic logic is_jump(input ctl_class_e c);
        return (c == CLS_JAL) || (c == CLS_JALR);
    endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  cond_e           cond,
    output logic            hit
);
    cmp_flags_t flags;

    always_comb begin
        flags.eq   = (opa == opb);
        flags.lt_u = (opa < opb);
        flags.lt_s = ($signed(opa) < $signed(opb));
    end

    always_comb begin
        unique case (cond)
            CND_EQ:  hit = flags.eq;
            CND_NE:  hit = !flags.eq;
            CND_LT:  hit = flags.lt_s;
            CND_GE:  hit = !flags.lt_s;
            CND_LTU: hit = flags.lt_u;
            CND_GEU: hit = !flags.lt_u;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base_reg,
    input  logic [XLEN-1:0] imm,
    input  ctl_class_e      cls,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] redirect_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] hw_off;
    logic [XLEN-1:0] pc_rel;
    logic [XLEN-1:0] reg_rel;

    assign hw_off  = {imm[XLEN-2:0], 1'b0};
    assign seq_pc  = pc + STEP;
    assign pc_rel  = pc + hw_off;
    assign reg_rel = base_reg + imm;

    always_comb begin
        if (cls == CLS_JALR)
            redirect_pc = {reg_rel[XLEN-1:1], 1'b0};
        else
            redirect_pc = pc_rel;
    end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
    parameter int          XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    input  logic [XLEN-1:0] d,
    output logic [XLEN-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RESET_VEC;
        else if (step_en)
            q <= d;
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN      = XLEN_DEF,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step_en,
    input  logic [1:0]           ctl_class,
    input  logic [2:0]           cond,
    input  logic [XLEN-1:0]      rs1_val,
    input  logic [XLEN-1:0]      rs2_val,
    input  logic [XLEN-1:0]      imm,
    input  logic [REG_IDX_W-1:0] dest_idx,
    output logic [XLEN-1:0]      pc_q,
    output logic [XLEN-1:0]      next_pc,
    output logic                 taken,
    output logic [XLEN-1:0]      link_val,
    output logic                 link_we
);
    ctl_class_e      cls;
    cond_e           cnd;
    logic            br_hit;
    logic            jump;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] redirect_pc;

    assign cls = ctl_class_e'(ctl_class);
    assign cnd = cond_e'(cond);

    npc_cond_eval #(.XLEN(XLEN)) u_cond (
        .opa  (rs1_val),
        .opb  (rs2_val),
        .cond (cnd),
        .hit  (br_hit)
    );

    npc_target_gen #(.XLEN(XLEN)) u_tgt (
        .pc          (pc_q),
        .base_reg    (rs1_val),
        .imm         (imm),
        .cls         (cls),
        .seq_pc      (seq_pc),
        .redirect_pc (redirect_pc)
    );

    assign jump = is_jump(cls);

    always_comb begin
        unique case (cls)
            CLS_BRANCH:       taken = br_hit;
            CLS_JAL, CLS_JALR: taken = 1'b1;
            default:          taken = 1'b0;
        endcase
    end

    assign next_pc  = taken ? redirect_pc : seq_pc;
    assign link_val = jump ? seq_pc : '0;
    assign link_we  = jump && (dest_idx != '0);

    npc_pc_reg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .d       (next_pc),
        .q       (pc_q)
    );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            step_en,
    input logic [1:0]      ctl_class,
    input logic [4:0]      dest_idx,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic            link_we
);
    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    assert_reset_vec_R1: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(rst)) |-> (pc_q == RESET_VEC));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_class == 2'd0) |-> (!taken && next_pc == pc_q + 32'd4));

    assert_jalr_even_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_class == 2'd3) |-> (taken && next_pc[0] == 1'b0));

    assert_jal_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_class == 2'd2) |-> taken);

    assert_no_link_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_class[1] == 1'b0 || dest_idx == 5'd0) |-> !link_we);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(rst) && !$past(step_en)) |-> $stable(pc_q));

    assert_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(rst) && $past(step_en)) |-> (pc_q == $past(next_pc)));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .ctl_class (ctl_class),
    .dest_idx  (dest_idx),
    .pc_q      (pc_q),
    .next_pc   (next_pc),
    .taken     (taken),
    .link_we   (link_we)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    localparam logic [31:0] RV = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [1:0]  ctl_class = 2'd0;
    logic [2:0]  cond = 3'd0;
    logic [31:0] rs1_val = '0, rs2_val = '0, imm = '0;
    logic [4:0]  dest_idx = '0;
    logic [31:0] pc_q, next_pc, link_val;
    logic        taken, link_we;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_pc;
    bit done = 0;

    always #4 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) u_npc_unit (
        .clk(clk), .rst(rst), .step_en(step_en), .ctl_class(ctl_class),
        .cond(cond), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm),
        .dest_idx(dest_idx), .pc_q(pc_q), .next_pc(next_pc), .taken(taken),
        .link_val(link_val), .link_we(link_we)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One vector: drive after negedge, compare, let the edge pass, update model.
    task automatic apply(input logic en, input logic [1:0] c, input logic [2:0] cd,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] im, input logic [4:0] rd);
        logic        e_tk;
        logic [31:0] e_np, e_lv;
        logic        e_we;
        string       ttag, ptag;
        step_en = en; ctl_class = c; cond = cd;
        rs1_val = a; rs2_val = b; imm = im; dest_idx = rd;
        #1;
        e_tk = 0; ttag = "R2"; ptag = "R2";
        if (c == 2'd1) begin
            ptag = "R6";
            if (cd == 3'b000)      begin e_tk = (a == b); ttag = "R3"; end
            else if (cd == 3'b001) begin e_tk = (a != b); ttag = "R3"; end
            else if (cd == 3'b100) begin e_tk = ($signed(a) <  $signed(b)); ttag = "R4"; end
            else if (cd == 3'b101) begin e_tk = ($signed(a) >= $signed(b)); ttag = "R4"; end
            else if (cd == 3'b110) begin e_tk = (a <  b); ttag = "R5"; end
            else if (cd == 3'b111) begin e_tk = (a >= b); ttag = "R5"; end
            else                   begin e_tk = 0; ttag = "R11"; end
        end else if (c == 2'd2) begin e_tk = 1; ttag = "R7"; ptag = "R7"; end
        else if (c == 2'd3)     begin e_tk = 1; ttag = "R8"; ptag = "R8"; end
        if (!e_tk)          e_np = model_pc + 32'd4;
        else if (c == 2'd3) e_np = (a + im) & ~32'd1;
        else                e_np = model_pc + im * 32'd2;
        e_lv = (c >= 2'd2) ? model_pc + 32'd4 : 32'd0;
        e_we = (c >= 2'd2) && (rd != 5'd0);
        cmp("R10 pc_q", pc_q, model_pc);
        cmp({ttag, " taken"}, {31'd0, taken}, {31'd0, e_tk});
        cmp({ptag, " next_pc"}, next_pc, e_np);
        cmp("R9 link_val", link_val, e_lv);
        cmp("R9 link_we", {31'd0, link_we}, {31'd0, e_we});
        @(posedge clk);
        if (en) model_pc = e_np;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_pc = RV;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cmp("R1 reset pc", pc_q, RV);
        @(negedge clk);
        // R10 hold: step_en low with a jump presented
        apply(0, 2'd2, 3'd0, 32'd0, 32'd0, 32'd64, 5'd1);
        apply(1, 2'd0, 3'd0, 32'd0, 32'd0, 32'd0, 5'd0);          // R2
        apply(1, 2'd3, 3'd0, 32'h2000, 32'd0, 32'd0, 5'd1);       // R8 to 0x2000
        apply(1, 2'd1, 3'b000, 32'd5, 32'd5, 32'd8, 5'd0);        // R3 eq taken
        apply(1, 2'd1, 3'b000, 32'd5, 32'd6, 32'd8, 5'd0);        // R3 eq not
        apply(1, 2'd1, 3'b001, 32'd5, 32'd6, 32'hFFFF_FFFC, 5'd0);// R3 ne taken, back
        apply(1, 2'd1, 3'b100, 32'hFFFF_FFFF, 32'd1, 32'd4, 5'd0);// R4 lt signed taken
        apply(1, 2'd1, 3'b110, 32'hFFFF_FFFF, 32'd1, 32'd4, 5'd0);// R5 ltu not
        apply(1, 2'd1, 3'b101, 32'd7, 32'd7, 32'd4, 5'd0);        // R4 ge equal
        apply(1, 2'd1, 3'b111, 32'd1, 32'hFFFF_FFFF, 32'd4, 5'd0);// R5 geu not
        apply(1, 2'd1, 3'b010, 32'd3, 32'd3, 32'd4, 5'd0);        // R11
        apply(1, 2'd1, 3'b011, 32'd3, 32'd4, 32'd4, 5'd0);        // R11
        apply(1, 2'd2, 3'd0, 32'd0, 32'd0, 32'hFFFF_FFF0, 5'd1);  // R7 backwards
        apply(1, 2'd3, 3'd0, 32'h3001, 32'd0, 32'd2, 5'd0);       // R8 odd, R9 x0
        apply(0, 2'd0, 3'd0, 32'd0, 32'd0, 32'd0, 5'd0);          // R10 hold
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = (i % 4 == 0) ? a : $urandom;
            if (i % 8 == 1) b = a ^ 32'h8000_0000;
            apply(1'($urandom), 2'($urandom), 3'($urandom), a, b,
                  {{20{1'($urandom)}}, 12'($urandom)}, 5'($urandom));
        end
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_pc = RV;
        #1;
        cmp("R1 second reset", pc_q, RV);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule